// File: doc/BRIEF.md
# Universal Shift/Storage Register with Shared Parallel Bus

This block is a clocked storage register, eight bits wide by default, with four operating modes. A two-bit mode select chooses the mode. The register can keep its contents, shift toward its high end, shift toward its low end, or capture a parallel word. Each shift direction has its own serial input, which feeds the bit that the shift leaves empty.

The parallel load data and the parallel register outputs share one bidirectional bus. The block models that bus as an input bus, an output bus and a single drive-enable. The block turns the bus around itself: it releases the drivers during a load so that outside data can be captured. It also releases them whenever either of the two active-low output enables is high.

The lowest and highest register bits also leave the block on dedicated serial outputs. These stay valid whatever the enables do, so several registers can be chained. An active-low master reset clears the register at once, without waiting for a clock edge.

Top module: `ushr_top`

## Requirements
- R1: While `rst_n` is low, all register bits are zero. The clear takes effect as soon as `rst_n` falls, with no clock edge needed.
- R2: With `mode_sel` = 2'b00 (keep), a rising clock edge leaves the register unchanged, whatever `bus_in` and the serial inputs carry.
- R3: With `mode_sel` = 2'b01 (shift up), a rising edge moves bit n into bit n+1, loads `ser_up_in` into bit 0 and drops the old top bit.
- R4: With `mode_sel` = 2'b10 (shift down), a rising edge moves bit n into bit n-1, loads `ser_dn_in` into the top bit and drops the old bit 0.
- R5: With `mode_sel` = 2'b11 (load), a rising edge copies `bus_in` into the register.
- R6: `bus_drive` is 1 exactly when every bit of `oe_n` is 0 and `mode_sel` is not 2'b11. While `bus_drive` is 1, `bus_out` equals the register contents.
- R7: `end_lo` always equals register bit 0 and `end_hi` always equals the top bit, whatever the values of `oe_n` and `mode_sel`.
- R8: Reset overrides every mode: an edge with `rst_n` low leaves the register at zero even in load mode. After release, the register stays zero through keep-mode edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low master clear |
| mode_sel | input | 2 | 00 keep, 01 shift up, 10 shift down, 11 load |
| ser_up_in | input | 1 | Serial bit entering bit 0 on a shift up |
| ser_dn_in | input | 1 | Serial bit entering the top bit on a shift down |
| oe_n | input | 2 | Active-low output enables; all must be low to drive the bus |
| bus_in | input | 8 | Value seen on the shared bus pins |
| bus_out | output | 8 | Value the block puts on the shared bus pins |
| bus_drive | output | 1 | High when the block drives the shared bus |
| end_lo | output | 1 | Always-valid copy of register bit 0 |
| end_hi | output | 1 | Always-valid copy of the register top bit |

## Verification
The register can be read only through the shared bus when it is driven, and through the two end outputs at any time. A wrong bit in the stored word therefore shows on `bus_out` in the first keep-mode cycle after the faulty edge. A wrong end bit shows on `end_lo` or `end_hi` right away, even with the bus released. An error in a shift direction or in the serial input it takes shows after one edge as a word that is displaced the wrong way or has the wrong new end bit. A fault in the turn-around logic shows at once as a wrong `bus_drive` for some combination of enables and mode.

// File: rtl/ushr_pkg.sv
package ushr_pkg;

   typedef enum logic [1:0] {
      MODE_KEEP = 2'b00,
      MODE_UP   = 2'b01,
      MODE_DN   = 2'b10,
      MODE_LOAD = 2'b11
   } ushr_mode_e;

endpackage

// File: rtl/ushr_next.sv
module ushr_next
   import ushr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] cur,
   input  ushr_mode_e       mode,
   input  logic             ser_up,
   input  logic             ser_dn,
   input  logic [WIDTH-1:0] par_in,
   output logic [WIDTH-1:0] nxt
);

   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("ushr_next: WIDTH must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_below;
      logic from_above;

      if (i == 0) begin : g_low_end
         assign from_below = ser_up;
      end else begin : g_low_mid
         assign from_below = cur[i-1];
      end

      if (i == TOP) begin : g_high_end
         assign from_above = ser_dn;
      end else begin : g_high_mid
         assign from_above = cur[i+1];
      end

      always_comb begin
         unique case (mode)
            MODE_KEEP: nxt[i] = cur[i];
            MODE_UP:   nxt[i] = from_below;
            MODE_DN:   nxt[i] = from_above;
            MODE_LOAD: nxt[i] = par_in[i];
            default:   nxt[i] = cur[i];
         endcase
      end
   end

endmodule

// File: rtl/ushr_store.sv
module ushr_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("ushr_store: WIDTH must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= nxt;
      end
   end

   AST_CLEAR_WHILE_RESET: assert property (@(posedge clk) !rst_n |-> (q == '0)); // R1

endmodule

// File: rtl/ushr_drive.sv
module ushr_drive
   import ushr_pkg::*;
#(
   parameter int NUM_OE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_OE-1:0] oe_n,
   input  ushr_mode_e        mode,
   output logic              drive
);

   if (NUM_OE < 1) begin : g_bad_oe
      $error("ushr_drive: NUM_OE must be at least 1");
   end

   logic all_enabled;

   if (NUM_OE == 1) begin : g_single
      assign all_enabled = ~oe_n[0];
   end else begin : g_multi
      assign all_enabled = ~|oe_n;
   end

   assign drive = all_enabled && (mode != MODE_LOAD);

   AST_RELEASE_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LOAD) |-> !drive); // R6
   AST_RELEASE_ON_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n != '0) |-> !drive); // R6

endmodule

// File: rtl/ushr_top.sv
module ushr_top
   import ushr_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int NUM_OE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic              ser_up_in,
   input  logic              ser_dn_in,
   input  logic [NUM_OE-1:0] oe_n,
   input  logic [WIDTH-1:0]  bus_in,
   output logic [WIDTH-1:0]  bus_out,
   output logic              bus_drive,
   output logic              end_lo,
   output logic              end_hi
);

   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("ushr_top: WIDTH must be at least 2");
   end

   ushr_mode_e       mode;
   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] nxt;

   assign mode = ushr_mode_e'(mode_sel);

   ushr_next #(.WIDTH(WIDTH)) u_next (
      .cur    (q),
      .mode   (mode),
      .ser_up (ser_up_in),
      .ser_dn (ser_dn_in),
      .par_in (bus_in),
      .nxt    (nxt)
   );

   ushr_store #(.WIDTH(WIDTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt   (nxt),
      .q     (q)
   );

   ushr_drive #(.NUM_OE(NUM_OE)) u_drive (
      .clk   (clk),
      .rst_n (rst_n),
      .oe_n  (oe_n),
      .mode  (mode),
      .drive (bus_drive)
   );

   assign bus_out = bus_drive ? q : '0;
   assign end_lo  = q[0];
   assign end_hi  = q[TOP];

   AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_KEEP) |=> $stable(q)); // R2
   AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_UP) |=> (q == {$past(q[TOP-1:0]), $past(ser_up_in)})); // R3
   AST_SHIFT_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DN) |=> (q == {$past(ser_dn_in), $past(q[TOP:1])})); // R4
   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LOAD) |=> (q == $past(bus_in))); // R5
   AST_BUS_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> (bus_out == q)); // R6

endmodule

// File: tb/sim_ushr_top.sv
module sim_ushr_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic       ser_up_in = 1'b0;
   logic       ser_dn_in = 1'b0;
   logic [1:0] oe_n = 2'b00;
   logic [7:0] bus_in = 8'h00;
   logic [7:0] bus_out;
   logic       bus_drive;
   logic       end_lo;
   logic       end_hi;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ushr_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .ser_up_in (ser_up_in),
      .ser_dn_in (ser_dn_in),
      .oe_n      (oe_n),
      .bus_in    (bus_in),
      .bus_out   (bus_out),
      .bus_drive (bus_drive),
      .end_lo    (end_lo),
      .end_hi    (end_hi)
   );

   // fields: [19:18] mode, [17] ser_up, [16] ser_dn, [15:8] bus_in, [7:0] expected word
   localparam logic [19:0] VEC [12] = '{
      {2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},
      {2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},
      {2'b01, 1'b0, 1'b0, 8'h00, 8'h96},
      {2'b10, 1'b0, 1'b1, 8'h00, 8'hCB},
      {2'b10, 1'b0, 1'b0, 8'h00, 8'h65},
      {2'b00, 1'b1, 1'b1, 8'hFF, 8'h65},
      {2'b11, 1'b0, 1'b0, 8'h3C, 8'h3C},
      {2'b01, 1'b1, 1'b0, 8'h00, 8'h79},
      {2'b10, 1'b0, 1'b0, 8'h00, 8'h3C},
      {2'b11, 1'b0, 1'b0, 8'h00, 8'h00},
      {2'b10, 1'b0, 1'b1, 8'h00, 8'h80},
      {2'b01, 1'b0, 1'b0, 8'h00, 8'h00}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [1:0] m);
      case (m)
         2'b00:   return "R2 keep";
         2'b01:   return "R3 shift up";
         2'b10:   return "R4 shift down";
         default: return "R5 load";
      endcase
   endfunction

   // apply one mode for one edge, then switch to keep and read the word over the bus
   task automatic step(input logic [1:0] m, input logic su, input logic sd, input logic [7:0] d);
      @(negedge clk);
      mode_sel = m; ser_up_in = su; ser_dn_in = sd; bus_in = d; oe_n = 2'b00;
      @(negedge clk);
      mode_sel = 2'b00;
      #1;
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // reset state, R1
      repeat (2) @(negedge clk);
      #1;
      check("R1 reset word", bus_out, 8'h00);
      check("R1 end bits", {6'b0, end_hi, end_lo}, 8'h00);
      rst_n = 1'b1;

      // table walk, R2 R3 R4 R5 R6
      for (int i = 0; i < 12; i++) begin
         step(VEC[i][19:18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
         check(tag_of(VEC[i][19:18]), bus_out, VEC[i][7:0]);
         check("R6 drive in keep", {7'b0, bus_drive}, 8'h01);
      end

      // R6: turn-around
      @(negedge clk);
      mode_sel = 2'b11; oe_n = 2'b00; #1;
      check("R6 released in load", {7'b0, bus_drive}, 8'h00);
      mode_sel = 2'b00; oe_n = 2'b01; #1;
      check("R6 released oe0 high", {7'b0, bus_drive}, 8'h00);
      oe_n = 2'b10; #1;
      check("R6 released oe1 high", {7'b0, bus_drive}, 8'h00);

      // R7: end outputs with bus released
      step(2'b11, 1'b0, 1'b0, 8'h81);
      oe_n = 2'b11; #1;
      check("R7 ends 81", {6'b0, end_hi, end_lo}, 8'h03);
      step(2'b11, 1'b0, 1'b0, 8'h01);
      oe_n = 2'b11; mode_sel = 2'b11; #1;
      check("R7 ends 01", {6'b0, end_hi, end_lo}, 8'h01);
      step(2'b11, 1'b0, 1'b0, 8'hFE);
      oe_n = 2'b01; #1;
      check("R7 ends FE", {6'b0, end_hi, end_lo}, 8'h02);
      oe_n = 2'b00; #1;
      check("R5 load FE", bus_out, 8'hFE);

      // R1: asynchronous clear mid-cycle
      @(negedge clk);
      #3 rst_n = 1'b0;
      #1;
      check("R1 async clear", bus_out, 8'h00);

      // R8: load under reset has no effect
      @(negedge clk);
      mode_sel = 2'b11; bus_in = 8'hFF;
      @(negedge clk);
      mode_sel = 2'b00; #1;
      check("R8 reset beats load", bus_out, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      check("R8 zero after release", bus_out, 8'h00);
      step(2'b01, 1'b1, 1'b0, 8'hFF);
      check("R3 first shift after reset", bus_out, 8'h01);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule